// File: doc/BRIEF.md
# Clock Source and PLL Enable Controller

This block decides which oscillators run, whether the 4x frequency multiplier is engaged, and which source drives the system clock. It works from four inputs: a 4-bit oscillator configuration code, a 3-bit internal frequency select, a software multiplier enable bit and the current power-managed mode. It drives enable lines for four oscillators: primary (external), secondary (timer crystal), high-frequency internal and low-frequency internal. It also drives a multiplier-active flag, a 2-bit clock-source code, and a masked read-back of the software multiplier bit.

The analog oscillators, the multiplier circuit and the glitch-free clock switch are outside the block. They consume its outputs. All outputs are registered. A change at the inputs shows at the outputs after one clock edge.

Top module: `clk_src_ctrl`

## Requirements
- R1: With configuration code 0110 (external crystal with multiplier) in primary-run or primary-idle mode, `pll_active` is 1 whatever `pll_sw_en` holds, `pri_osc_en` is 1 and `clk_sel` is 00.
- R2: With configuration code 1000 or 1001 (internal block), `pll_active` is 1 in primary-run or primary-idle mode only when `pll_sw_en` is 1 and `int_fsel` is 110 or 111. Outside the two primary modes, `pll_active` is 0.
- R3: `pll_en_rb` equals `pll_sw_en` when the configuration is 1000 or 1001 and `int_fsel` is 110 or 111. In every other case it reads 0, code 0110 included.
- R4: `pri_osc_en` is 1 only in primary-run (mode 0) or primary-idle (mode 1) with a configuration other than 1000 or 1001. In all other modes it is 0.
- R5: In secondary-run (mode 2) and secondary-idle (mode 3), `sec_osc_en` is 1 and `clk_sel` is 01.
- R6: In internal-run (mode 4) and internal-idle (mode 5), the internal block drives the clock. Likewise, an internal configuration in a primary mode uses the internal block. In these cases `clk_sel` is 10 with `hf_osc_en` at 1, or 11 with `lf_osc_en` at 1 when `int_fsel` is 000.
- R7: When the low-frequency source is selected directly (`int_fsel` 000), `hf_osc_en` is 0.
- R8: In sleep (mode 6, and the unused code 7), `pri_osc_en`, `hf_osc_en` and `pll_active` are 0 and `clk_sel` is 11. `sec_osc_en` and `lf_osc_en` are 0 unless independently requested.
- R9: `wdt_en` at 1 holds `lf_osc_en` at 1 in every mode. `t1_osc_req` at 1 holds `sec_osc_en` at 1 in every mode.
- R10: Every output changes exactly one clock edge after its inputs change, never in the same cycle.
- R11: A clock edge with `rst_n` low sets `lf_osc_en` to 1 and `clk_sel` to 11, and clears every other output, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_cfg | input | 4 | Oscillator configuration code |
| int_fsel | input | 3 | Internal frequency select |
| pll_sw_en | input | 1 | Software multiplier enable bit |
| pm_mode | input | 3 | Power mode: 0 pri-run, 1 pri-idle, 2 sec-run, 3 sec-idle, 4 int-run, 5 int-idle, 6 sleep |
| wdt_en | input | 1 | Watchdog needs the low-frequency source |
| t1_osc_req | input | 1 | Timer needs the secondary oscillator |
| pri_osc_en | output | 1 | Primary oscillator enable |
| sec_osc_en | output | 1 | Secondary oscillator enable |
| hf_osc_en | output | 1 | High-frequency internal enable |
| lf_osc_en | output | 1 | Low-frequency internal enable |
| pll_active | output | 1 | 4x multiplier engaged |
| clk_sel | output | 2 | 00 primary, 01 secondary, 10 HF internal, 11 LF internal |
| pll_en_rb | output | 1 | Effective software multiplier bit |

## Verification
Any wrong state in this block sits in the single output register. A mistake therefore appears at the ports one edge after the input pattern that exposes it, and persists until the inputs change. A wrong multiplier decision appears on `pll_active` or `pll_en_rb` in the next cycle. Examples are an unmasked software bit under code 0110, or a frequency select that fails to gate. A wrong mode decode appears as an enable that should be off, or as a `clk_sel` code that names an oscillator which is disabled. The bench checks each mode with and without the independent requests so that both kinds of fault surface.

// File: rtl/clk_src_pkg.sv
// Shared types and codes for the clock source controller.
// Assumes mode codes above PM_SLEEP are treated as sleep.
package clk_src_pkg;

    typedef enum logic [2:0] {
        PM_PRI_RUN  = 3'd0,
        PM_PRI_IDLE = 3'd1,
        PM_SEC_RUN  = 3'd2,
        PM_SEC_IDLE = 3'd3,
        PM_INT_RUN  = 3'd4,
        PM_INT_IDLE = 3'd5,
        PM_SLEEP    = 3'd6,
        PM_RSVD     = 3'd7
    } pm_mode_t;

    typedef enum logic [1:0] {
        SEL_PRI = 2'b00,
        SEL_SEC = 2'b01,
        SEL_HF  = 2'b10,
        SEL_LF  = 2'b11
    } clk_sel_t;

    typedef struct packed {
        logic     pri_en;
        logic     sec_en;
        logic     hf_en;
        logic     lf_en;
        logic     pll_on;
        clk_sel_t sel;
        logic     pll_rb;
    } clk_ctl_t;

    localparam clk_ctl_t CTL_RESET = '{
        pri_en: 1'b0, sec_en: 1'b0, hf_en: 1'b0, lf_en: 1'b1,
        pll_on: 1'b0, sel: SEL_LF, pll_rb: 1'b0
    };

endpackage

// File: rtl/clk_src_pll_gate.sv
// Multiplier qualification. Decides whether the configuration is the
// internal block, whether the multiplier may run, and the masked
// read-back of the software enable bit. Purely combinational.
// Assumes the two internal codes and the two qualifying frequency codes
// are given as parameters.
module clk_src_pll_gate #(
    parameter int             CFG_W      = 4,
    parameter int             FSEL_W     = 3,
    parameter logic [CFG_W-1:0]  CFG_XPLL   = 4'b0110,
    parameter logic [CFG_W-1:0]  CFG_INT_A  = 4'b1000,
    parameter logic [CFG_W-1:0]  CFG_INT_B  = 4'b1001,
    parameter logic [FSEL_W-1:0] FSEL_HI_A  = 3'b110,
    parameter logic [FSEL_W-1:0] FSEL_HI_B  = 3'b111
) (
    input  logic [CFG_W-1:0]  osc_cfg,
    input  logic [FSEL_W-1:0] int_fsel,
    input  logic              pll_sw_en,
    output logic              cfg_internal,
    output logic              pll_req,
    output logic              pll_rb
);

    logic cfg_xpll;
    logic fsel_ok;

    // Decode configuration class and frequency eligibility.
    always_comb begin
        cfg_xpll     = (osc_cfg == CFG_XPLL);
        cfg_internal = (osc_cfg == CFG_INT_A) || (osc_cfg == CFG_INT_B);
        fsel_ok      = (int_fsel == FSEL_HI_A) || (int_fsel == FSEL_HI_B);
    end

    // Software bit only survives where the multiplier is offered to it.
    always_comb begin
        pll_rb  = cfg_internal && fsel_ok && pll_sw_en;
        pll_req = cfg_xpll || pll_rb;
    end

endmodule

// File: rtl/clk_src_route.sv
// Power-mode router. Turns the mode, the configuration class and the
// independent requests into the next set of enables and the select code.
// Purely combinational; the caller registers the result.
module clk_src_route
    import clk_src_pkg::*;
(
    input  pm_mode_t mode,
    input  logic     cfg_internal,
    input  logic     lf_direct,
    input  logic     pll_req,
    input  logic     pll_rb,
    input  logic     wdt_en,
    input  logic     t1_osc_req,
    output clk_ctl_t nxt
);

    logic pri_mode, sec_mode, int_mode, use_intblk;

    // Classify the mode.
    always_comb begin
        pri_mode   = (mode == PM_PRI_RUN) || (mode == PM_PRI_IDLE);
        sec_mode   = (mode == PM_SEC_RUN) || (mode == PM_SEC_IDLE);
        int_mode   = (mode == PM_INT_RUN) || (mode == PM_INT_IDLE);
        use_intblk = int_mode || (pri_mode && cfg_internal);
    end

    // Build enables and select code for the next cycle.
    always_comb begin
        nxt        = CTL_RESET;
        nxt.pri_en = pri_mode && !cfg_internal;
        nxt.sec_en = sec_mode || t1_osc_req;
        nxt.hf_en  = use_intblk && !lf_direct;
        nxt.lf_en  = wdt_en || (use_intblk && lf_direct);
        nxt.pll_on = pri_mode && pll_req;
        nxt.pll_rb = pll_rb;
        if (sec_mode)
            nxt.sel = SEL_SEC;
        else if (use_intblk)
            nxt.sel = lf_direct ? SEL_LF : SEL_HF;
        else if (pri_mode)
            nxt.sel = SEL_PRI;
        else
            nxt.sel = SEL_LF;
    end

endmodule

// File: rtl/clk_src_ctrl.sv
// Clock source and multiplier enable controller (top).
// Registers the decisions of the multiplier gate and the mode router.
// Assumes inputs are synchronous to clk; reset is synchronous, active low.
module clk_src_ctrl
    import clk_src_pkg::*;
#(
    parameter int                CFG_W   = 4,
    parameter int                FSEL_W  = 3,
    parameter logic [FSEL_W-1:0] FSEL_LF = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  osc_cfg,
    input  logic [FSEL_W-1:0] int_fsel,
    input  logic              pll_sw_en,
    input  logic [2:0]        pm_mode,
    input  logic              wdt_en,
    input  logic              t1_osc_req,
    output logic              pri_osc_en,
    output logic              sec_osc_en,
    output logic              hf_osc_en,
    output logic              lf_osc_en,
    output logic              pll_active,
    output logic [1:0]        clk_sel,
    output logic              pll_en_rb
);

    logic     cfg_internal, pll_req, pll_rb, lf_direct;
    clk_ctl_t nxt, cur;

    // Direct low-frequency selection from the frequency code.
    always_comb lf_direct = (int_fsel == FSEL_LF);

    clk_src_pll_gate #(
        .CFG_W (CFG_W),
        .FSEL_W(FSEL_W)
    ) u_gate (
        .osc_cfg     (osc_cfg),
        .int_fsel    (int_fsel),
        .pll_sw_en   (pll_sw_en),
        .cfg_internal(cfg_internal),
        .pll_req     (pll_req),
        .pll_rb      (pll_rb)
    );

    clk_src_route u_route (
        .mode        (pm_mode_t'(pm_mode)),
        .cfg_internal(cfg_internal),
        .lf_direct   (lf_direct),
        .pll_req     (pll_req),
        .pll_rb      (pll_rb),
        .wdt_en      (wdt_en),
        .t1_osc_req  (t1_osc_req),
        .nxt         (nxt)
    );

    // Output register: one cycle from input change to output.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= CTL_RESET;
        else        cur <= nxt;
    end

    // Drive ports from the register.
    always_comb begin
        pri_osc_en = cur.pri_en;
        sec_osc_en = cur.sec_en;
        hf_osc_en  = cur.hf_en;
        lf_osc_en  = cur.lf_en;
        pll_active = cur.pll_on;
        clk_sel    = cur.sel;
        pll_en_rb  = cur.pll_rb;
    end

    // R1: external multiplier config in a primary mode forces the multiplier on.
    a_r1_xpll_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_cfg == 4'b0110 && pm_mode <= 3'd1) |=>
        (pll_active && pri_osc_en && clk_sel == 2'b00));

    // R3: read-back is masked outside the internal configurations.
    a_r3_rb_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_cfg == 4'b1000 || osc_cfg == 4'b1001) |=> !pll_en_rb);

    // R5: secondary modes select and enable the secondary oscillator.
    a_r5_sec_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 3'd2 || pm_mode == 3'd3) |=> (sec_osc_en && clk_sel == 2'b01));

    // R7: the HF oscillator never runs while LF is the selected clock.
    a_r7_hf_off_on_lf: assert property (@(posedge clk) disable iff (!rst_n)
        (int_fsel == FSEL_LF) |=> !hf_osc_en);

    // R8: sleep without requests leaves every oscillator off.
    a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode >= 3'd6 && !wdt_en && !t1_osc_req) |=>
        (!pri_osc_en && !sec_osc_en && !hf_osc_en && !lf_osc_en && !pll_active));

    // R9: independent requests keep their sources alive.
    a_r9_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_en || t1_osc_req) |=> ((lf_osc_en || !$past(wdt_en)) &&
                                     (sec_osc_en || !$past(t1_osc_req))));

endmodule

// File: tb/sim_clk_src_ctrl.sv
module sim_clk_src_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] osc_cfg;
    logic [2:0] int_fsel;
    logic       pll_sw_en;
    logic [2:0] pm_mode;
    logic       wdt_en;
    logic       t1_osc_req;
    logic       pri_osc_en, sec_osc_en, hf_osc_en, lf_osc_en, pll_active, pll_en_rb;
    logic [1:0] clk_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_src_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .osc_cfg(osc_cfg), .int_fsel(int_fsel),
        .pll_sw_en(pll_sw_en), .pm_mode(pm_mode), .wdt_en(wdt_en),
        .t1_osc_req(t1_osc_req), .pri_osc_en(pri_osc_en), .sec_osc_en(sec_osc_en),
        .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en), .pll_active(pll_active),
        .clk_sel(clk_sel), .pll_en_rb(pll_en_rb)
    );

    // Vector: req[24:21] cfg[20:17] fsel[16:14] sw[13] mode[12:10] wdt[9] t1[8]
    //         expected pri[7] sec[6] hf[5] lf[4] pll[3] sel[2:1] rb[0]
    localparam logic [24:0] VEC [NVEC] = '{
        {4'd1, 4'b0110, 3'b000, 1'b0, 3'd0, 1'b0, 1'b0, 8'b1000_1_00_0}, // R1 sw=0
        {4'd3, 4'b0110, 3'b111, 1'b1, 3'd1, 1'b0, 1'b0, 8'b1000_1_00_0}, // R3 rb masked in xpll
        {4'd2, 4'b1001, 3'b111, 1'b1, 3'd0, 1'b0, 1'b0, 8'b0010_1_10_1}, // R2 16 MHz
        {4'd2, 4'b1000, 3'b110, 1'b1, 3'd0, 1'b0, 1'b0, 8'b0010_1_10_1}, // R2 8 MHz
        {4'd3, 4'b1000, 3'b101, 1'b1, 3'd0, 1'b0, 1'b0, 8'b0010_0_10_0}, // R3 freq not eligible
        {4'd2, 4'b1001, 3'b111, 1'b0, 3'd0, 1'b0, 1'b0, 8'b0010_0_10_0}, // R2 sw off
        {4'd4, 4'b0010, 3'b111, 1'b1, 3'd0, 1'b0, 1'b0, 8'b1000_0_00_0}, // R4 plain crystal
        {4'd5, 4'b0010, 3'b111, 1'b0, 3'd2, 1'b0, 1'b0, 8'b0100_0_01_0}, // R5 sec run
        {4'd5, 4'b1001, 3'b111, 1'b1, 3'd3, 1'b0, 1'b0, 8'b0100_0_01_1}, // R5 sec idle, pll off
        {4'd6, 4'b0010, 3'b110, 1'b0, 3'd4, 1'b0, 1'b0, 8'b0010_0_10_0}, // R6 int run HF
        {4'd7, 4'b0010, 3'b000, 1'b0, 3'd5, 1'b0, 1'b0, 8'b0001_0_11_0}, // R7 int idle LF
        {4'd7, 4'b1000, 3'b000, 1'b1, 3'd0, 1'b0, 1'b0, 8'b0001_0_11_0}, // R7 internal cfg LF
        {4'd8, 4'b0110, 3'b111, 1'b1, 3'd6, 1'b0, 1'b0, 8'b0000_0_11_0}, // R8 sleep quiet
        {4'd9, 4'b0110, 3'b111, 1'b1, 3'd6, 1'b1, 1'b1, 8'b0101_0_11_0}, // R9 sleep requests
        {4'd9, 4'b0010, 3'b111, 1'b0, 3'd4, 1'b1, 1'b1, 8'b0111_0_10_0}, // R9 int run requests
        {4'd9, 4'b0110, 3'b111, 1'b0, 3'd0, 1'b0, 1'b1, 8'b1100_1_00_0}  // R9 t1 in primary
    };

    function automatic logic [7:0] outs();
        return {pri_osc_en, sec_osc_en, hf_osc_en, lf_osc_en, pll_active, clk_sel, pll_en_rb};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [12:0] v);
        {osc_cfg, int_fsel, pll_sw_en, pm_mode, wdt_en, t1_osc_req} = v;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(13'b0110_111_1_000_0_0);
        repeat (2) @(negedge clk);
        // R11: reset state even with a multiplier config applied
        check("R11", outs(), 8'b0001_0_11_0);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][20:8]);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VEC[i][24:21], i), outs(), VEC[i][7:0]);
        end
        // R10: outputs hold until the next edge after an input change
        drive(13'b0010_111_0_010_0_0);
        @(negedge clk);
        drive(13'b0010_000_0_101_0_0);
        #1;
        check("R10 before edge", outs(), 8'b0100_0_01_0);
        @(negedge clk);
        check("R10 after edge", outs(), 8'b0001_0_11_0);
        // R8: reserved mode code behaves as sleep
        drive(13'b0010_111_0_111_0_0);
        @(negedge clk);
        check("R8 code7", outs(), 8'b0000_0_11_0);
        // R11: reset mid-run overrides a busy pattern
        drive(13'b0110_111_1_000_1_1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 midrun", outs(), 8'b0001_0_11_0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", outs(), 8'b1101_1_00_0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule